// File: doc/BRIEF.md
# Dual-Register Gray Pointer Counter

This block is a pointer counter for queues whose two ends run on unrelated clocks. Each pointer is kept in two registers. The first holds the count as plain binary and feeds the memory address directly. The second holds the matching Gray code, and logic in the other clock domain can sample that value safely. The count is kept in binary, so an ordinary adder carry chain does the arithmetic. One XOR per bit turns the next binary value into the next Gray value, and both registers load on the same clock edge. The Gray value is never decoded back to binary.

On each clock edge the counter steps by one when its enable is high and its inhibit is low. The inhibit input takes the queue's "cannot proceed" condition: full for a write pointer, empty for a read pointer. After the all-ones count the pointer wraps to zero. An active-low asynchronous reset clears both registers at once.

Top module: `gray_ptr_counter`

## Requirements
- R1: While `rst_n` is low, both `addr_bin` and `ptr_gray` are zero. Asserting `rst_n` low clears them without waiting for a clock edge.
- R2: On a rising clock edge with `inc_en` = 1 and `inhibit` = 0, `addr_bin` becomes its previous value plus one, modulo 2^PTR_W.
- R3: On a rising clock edge with `inc_en` = 0, `addr_bin` and `ptr_gray` keep their values.
- R4: On a rising clock edge with `inhibit` = 1, `addr_bin` and `ptr_gray` keep their values even when `inc_en` = 1.
- R5: A step from the all-ones count gives zero in both `addr_bin` and `ptr_gray`.
- R6: After every clock edge, bit i of `ptr_gray` equals `addr_bin[i] ^ addr_bin[i+1]` for i < PTR_W-1, and the top bit of `ptr_gray` equals the top bit of `addr_bin`.
- R7: When the pointer steps, the new `ptr_gray` differs from the old one in exactly one bit position, including across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the pointer's domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_en | input | 1 | Request to advance the pointer |
| inhibit | input | 1 | Blocks advance (queue full or empty) |
| ptr_gray | output | PTR_W | Registered Gray-coded pointer |
| addr_bin | output | PTR_W | Registered binary count, used as memory address |

## Verification
The wrap from all-ones to zero is the hardest case to reach, because it needs 2^PTR_W uninterrupted steps. It is also the case where a broken Gray conversion shows up as a change in more than one bit. The stimulus runs the counter past the wrap more than once. Between those runs it mixes blocked and idle cycles with inhibit held high while the enable is high. An asynchronous reset is applied between clock edges and checked before the next edge, so the clear is shown not to wait for the clock.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    // Action chosen for the pointer on the coming clock edge.
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_STEP = 2'd1
    } ptr_action_e;

endpackage

// File: rtl/gpc_next_calc.sv
module gpc_next_calc
    import gpc_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] bin_q,
    input  logic             inc_en,
    input  logic             inhibit,
    output ptr_action_e      action,
    output logic [PTR_W-1:0] bin_next
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    // Select step or hold from the request and the inhibit.
    always_comb begin
        if (inc_en && !inhibit) begin
            action = PTR_STEP;
        end else begin
            action = PTR_HOLD;
        end
    end

    // The binary adder wraps naturally at 2^PTR_W.
    always_comb begin
        unique case (action)
            PTR_STEP: bin_next = bin_q + ONE;
            PTR_HOLD: bin_next = bin_q;
            default:  bin_next = bin_q;
        endcase
    end

endmodule

// File: rtl/gpc_bin2gray.sv
module gpc_bin2gray #(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] bin_in,
    output logic [PTR_W-1:0] gray_out
);

    // One two-input XOR for each bit below the top; the top bit passes through.
    for (genvar i = 0; i < PTR_W - 1; i++) begin : g_xor
        assign gray_out[i] = bin_in[i] ^ bin_in[i+1];
    end
    assign gray_out[PTR_W-1] = bin_in[PTR_W-1];

endmodule

// File: rtl/gpc_regs.sv
module gpc_regs #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] bin_d,
    input  logic [PTR_W-1:0] gray_d,
    output logic [PTR_W-1:0] bin_q,
    output logic [PTR_W-1:0] gray_q
);

    // Binary count register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
        end else begin
            bin_q <= bin_d;
        end
    end

    // Gray copy register, loaded on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_q <= '0;
        end else begin
            gray_q <= gray_d;
        end
    end

endmodule

// File: rtl/gray_ptr_counter.sv
module gray_ptr_counter
    import gpc_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             inhibit,
    output logic [PTR_W-1:0] ptr_gray,
    output logic [PTR_W-1:0] addr_bin
);

    ptr_action_e      action;
    logic [PTR_W-1:0] bin_q;
    logic [PTR_W-1:0] bin_next;
    logic [PTR_W-1:0] gray_next;
    logic [PTR_W-1:0] gray_q;

    gpc_next_calc #(.PTR_W(PTR_W)) u_next (
        .bin_q    (bin_q),
        .inc_en   (inc_en),
        .inhibit  (inhibit),
        .action   (action),
        .bin_next (bin_next)
    );

    gpc_bin2gray #(.PTR_W(PTR_W)) u_conv (
        .bin_in   (bin_next),
        .gray_out (gray_next)
    );

    gpc_regs #(.PTR_W(PTR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .bin_d  (bin_next),
        .gray_d (gray_next),
        .bin_q  (bin_q),
        .gray_q (gray_q)
    );

    // The address is the binary register itself.
    assign addr_bin = bin_q;
    assign ptr_gray = gray_q;

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inc_en,
    input logic             inhibit,
    input logic [PTR_W-1:0] ptr_gray,
    input logic [PTR_W-1:0] addr_bin
);

    localparam logic [PTR_W-1:0] ALL_ONES = '1;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (addr_bin == '0 && ptr_gray == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !inhibit) |=> addr_bin == PTR_W'($past(addr_bin) + 1'b1));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_en |=> ($stable(addr_bin) && $stable(ptr_gray)));

    a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> ($stable(addr_bin) && $stable(ptr_gray)));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_bin == ALL_ONES && inc_en && !inhibit) |=> (addr_bin == '0 && ptr_gray == '0));

    a_r6_gray_match: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_gray == (addr_bin ^ (addr_bin >> 1)));

    a_r7_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_gray) |-> $countones(ptr_gray ^ $past(ptr_gray)) == 1);

endmodule

bind gray_ptr_counter gpc_checker #(.PTR_W(PTR_W)) u_gpc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (inc_en),
    .inhibit  (inhibit),
    .ptr_gray (ptr_gray),
    .addr_bin (addr_bin)
);

// File: tb/tb_gray_ptr_counter.sv
`timescale 1ns/1ps
module tb_gray_ptr_counter;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] bin;
        logic         stepped;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         inc_en = 1'b0;
    logic         inhibit = 1'b0;
    logic [W-1:0] ptr_gray;
    logic [W-1:0] addr_bin;

    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    exp_t         sb[$];
    logic [W-1:0] model_bin = '0;
    logic [W-1:0] prev_gray = '0;

    always #2 clk = ~clk;

    gray_ptr_counter #(.PTR_W(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (inc_en),
        .inhibit  (inhibit),
        .ptr_gray (ptr_gray),
        .addr_bin (addr_bin)
    );

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        logic [W-1:0] g;
        for (int i = 0; i < W; i++) begin
            g[i] = (i == W - 1) ? b[i] : (b[i] ^ b[i+1]);
        end
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: set the inputs for one edge and push the expected result.
    task automatic drive(input bit en, input bit inh, input string req);
        exp_t e;
        @(negedge clk);
        inc_en  = en;
        inhibit = inh;
        if (en && !inh) model_bin = model_bin + 1'b1;
        e.bin     = model_bin;
        e.stepped = en && !inh;
        e.req     = req;
        sb.push_back(e);
    endtask

    // Monitor: sample shortly after each rising edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(addr_bin == e.bin, e.req, addr_bin, e.bin);
                check(ptr_gray == to_gray(e.bin), "R6", ptr_gray, to_gray(e.bin));
                if (e.stepped) begin
                    check($countones(ptr_gray ^ prev_gray) == 1, "R7", ptr_gray, prev_gray);
                end else begin
                    check(ptr_gray == prev_gray, e.req, ptr_gray, prev_gray);
                end
                prev_gray = ptr_gray;
            end
        end
    end

    initial begin
        // R1: state held in reset
        #3;
        check(addr_bin == '0, "R1", addr_bin, '0);
        check(ptr_gray == '0, "R1", ptr_gray, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R5, R7: a full lap plus some, crossing the wrap
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, (model_bin == '1) ? "R5" : "R2");
        // R3: idle cycles
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, "R3");
        // R4: inhibit while requested, and inhibit alone
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, "R4");
        drive(1'b0, 1'b1, "R4");
        // mixed pattern across another wrap
        for (int i = 0; i < 40; i++) drive(i % 3 != 0, i % 5 == 0, "R2");
        @(negedge clk);
        inc_en = 1'b0;
        @(negedge clk);

        // R1: asynchronous clear between edges
        #0.5;
        rst_n = 1'b0;
        #0.5;
        check(addr_bin == '0, "R1", addr_bin, '0);
        check(ptr_gray == '0, "R1", ptr_gray, '0);
        model_bin = '0;
        prev_gray = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 17; i++) drive(1'b1, 1'b0, (model_bin == '1) ? "R5" : "R2");
        drive(1'b0, 1'b0, "R3");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule